// File: doc/BRIEF.md
# Two-Point Feedback Word Shift Buffer

This block is a long linear feedback shift register whose elements are blocks of eight 32-bit words. It holds 32 such blocks (stages), 8192 bits in all, and advances by one stage on every enabled iteration. A neighbouring round function reads two fixed stages, 4 and 16, and supplies either an external 8-word block (push mode) or eight words of its own state (pull mode) as the feedback block.

Feedback enters at two places. The new stage 0 is the old last stage XORed with the mode-selected feedback block. The new stage 25 is the old stage 24 XORed with a copy of the old last stage whose words are rotated by two positions. Every other stage takes the contents of its lower neighbour. A clear mode zeroes the whole buffer. The storage can be built as a true shift register or as a ring memory with a moving head pointer, and both variants look the same at the ports.

Top module: `lfsr_word_buf`

## Requirements
- R1: While `rst` is high at a rising edge, every stage becomes zero, so both tap outputs read zero in the following cycle.
- R2: With `en` high and `mode` = 2'b00 (clear), every stage becomes zero at the edge.
- R3: With `en` low, no stage changes, whatever `mode` and the data inputs carry.
- R4: On an advance (`en` high, `mode` 2'b01 or 2'b10), each stage j other than 0 and 25 takes the old stage j-1.
- R5: In push mode (`mode` = 2'b01) the new stage 0 is the old stage 31 XORed word by word with `push_blk`.
- R6: On an advance, word i of the new stage 25 is word i of old stage 24 XORed with word (i+2) mod 8 of old stage 31; word i sits in bits [32i+31:32i] of a block.
- R7: In pull mode (`mode` = 2'b10) the new stage 0 is the old stage 31 XORed with `state_blk`, whose word i carries state word i+1.
- R8: With `en` high and `mode` = 2'b11 (idle), no stage changes.
- R9: `tap_a` and `tap_b` show stages 4 and 16 of the current contents, before the update of the coming edge.
- R10: The ring-memory variant (`USE_RING` = 1) and the shift-register variant (`USE_RING` = 0) give identical tap outputs for identical input sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the buffer |
| en | input | 1 | Iteration enable |
| mode | input | 2 | 00 clear, 01 push, 10 pull, 11 idle |
| push_blk | input | 256 | External feedback block used in push mode |
| state_blk | input | 256 | State words 1..8 used as feedback in pull mode |
| tap_a | output | 256 | Current stage 4 |
| tap_b | output | 256 | Current stage 16 |

## Verification
The taps are combinational views of the stored stages, so the effect of an edge's inputs is due on the taps in the cycle right after that edge and nowhere earlier. The bench drives inputs on the falling edge, lets a behavioural model of 32 stages advance on the rising edge, and compares both taps of a ring instance and a shift instance at the next falling edge, every cycle. Feedback written into stage 0 or 25 first reaches a tap many edges later (stage 4 after four advances, stage 16 after sixteen or after a twist at 25 wraps round), so phases of push, pull, hold, idle and clear are each run long enough for their contributions to pass both taps.

// File: rtl/lfsr_buf_pkg.sv
package lfsr_buf_pkg;

    localparam int WORD_W_D    = 32;
    localparam int BLK_WORDS_D = 8;
    localparam int STAGES_D    = 32;

    typedef enum logic [1:0] {
        MD_CLEAR = 2'b00,
        MD_PUSH  = 2'b01,
        MD_PULL  = 2'b10,
        MD_IDLE  = 2'b11
    } buf_mode_e;

    // Decoded per-iteration control
    typedef struct packed {
        logic clr;
        logic adv;
        logic sel_push;
    } buf_ctl_t;

    function automatic buf_ctl_t decode_ctl(logic rst, logic en, buf_mode_e md);
        buf_ctl_t c;
        c.clr      = rst | (en & (md == MD_CLEAR));
        c.adv      = ~rst & en & ((md == MD_PUSH) | (md == MD_PULL));
        c.sel_push = (md == MD_PUSH);
        return c;
    endfunction

endpackage

// File: rtl/lfsr_fb.sv
module lfsr_fb #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 8,
    parameter int ROT_WORDS = 2,
    localparam int BLK_W    = WORD_W * BLK_WORDS
) (
    input  logic             sel_push,
    input  logic [BLK_W-1:0] push_blk,
    input  logic [BLK_W-1:0] state_blk,
    input  logic [BLK_W-1:0] last_stg,
    input  logic [BLK_W-1:0] twist_src,
    output logic [BLK_W-1:0] new_first,
    output logic [BLK_W-1:0] new_twist
);

    logic [BLK_W-1:0] q_blk;

    assign q_blk     = sel_push ? push_blk : state_blk;
    assign new_first = last_stg ^ q_blk;

    // word w of twisted stage mixes in word (w+ROT) of the last stage
    for (genvar w = 0; w < BLK_WORDS; w++) begin : g_twist
        localparam int SRC_W = (w + ROT_WORDS) % BLK_WORDS;
        assign new_twist[w*WORD_W +: WORD_W] =
            twist_src[w*WORD_W +: WORD_W] ^ last_stg[SRC_W*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/lfsr_store_shift.sv
module lfsr_store_shift #(
    parameter int BLK_W     = 256,
    parameter int STAGES    = 32,
    parameter int TAP_A     = 4,
    parameter int TAP_B     = 16,
    parameter int TWIST_STG = 25
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             adv,
    input  logic [BLK_W-1:0] new_first,
    input  logic [BLK_W-1:0] new_twist,
    output logic [BLK_W-1:0] tap_a,
    output logic [BLK_W-1:0] tap_b,
    output logic [BLK_W-1:0] twist_src,
    output logic [BLK_W-1:0] last_stg
);

    logic [BLK_W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int j = 0; j < STAGES; j++) st[j] <= '0;
        end else if (adv) begin
            st[0] <= new_first;
            for (int j = 1; j < STAGES; j++) begin
                if (j == TWIST_STG) st[j] <= new_twist;
                else                st[j] <= st[j-1];
            end
        end
    end

    assign tap_a     = st[TAP_A];
    assign tap_b     = st[TAP_B];
    assign twist_src = st[TWIST_STG-1];
    assign last_stg  = st[STAGES-1];

endmodule

// File: rtl/lfsr_store_ring.sv
module lfsr_store_ring #(
    parameter int BLK_W     = 256,
    parameter int STAGES    = 32,
    parameter int TAP_A     = 4,
    parameter int TAP_B     = 16,
    parameter int TWIST_STG = 25,
    localparam int PTR_W    = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             adv,
    input  logic [BLK_W-1:0] new_first,
    input  logic [BLK_W-1:0] new_twist,
    output logic [BLK_W-1:0] tap_a,
    output logic [BLK_W-1:0] tap_b,
    output logic [BLK_W-1:0] twist_src,
    output logic [BLK_W-1:0] last_stg
);

    // logical stage k lives at physical slot (head + k) mod STAGES
    localparam logic [PTR_W-1:0] OFF_A    = PTR_W'(TAP_A);
    localparam logic [PTR_W-1:0] OFF_B    = PTR_W'(TAP_B);
    localparam logic [PTR_W-1:0] OFF_SRC  = PTR_W'(TWIST_STG - 1);
    localparam logic [PTR_W-1:0] OFF_LAST = PTR_W'(STAGES - 1);

    logic [BLK_W-1:0] mem [STAGES];
    logic [PTR_W-1:0] head;

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int j = 0; j < STAGES; j++) mem[j] <= '0;
            head <= '0;
        end else if (adv) begin
            // after head steps back, slot of old last becomes stage 0
            // and slot of old stage TWIST_STG-1 becomes stage TWIST_STG
            mem[head + OFF_LAST] <= new_first;
            mem[head + OFF_SRC]  <= new_twist;
            head                 <= head - 1'b1;
        end
    end

    assign tap_a     = mem[head + OFF_A];
    assign tap_b     = mem[head + OFF_B];
    assign twist_src = mem[head + OFF_SRC];
    assign last_stg  = mem[head + OFF_LAST];

endmodule

// File: rtl/lfsr_word_buf.sv
module lfsr_word_buf
    import lfsr_buf_pkg::*;
#(
    parameter int WORD_W    = WORD_W_D,
    parameter int BLK_WORDS = BLK_WORDS_D,
    parameter int STAGES    = STAGES_D,
    parameter int TAP_A     = 4,
    parameter int TAP_B     = 16,
    parameter int TWIST_STG = 25,
    parameter int ROT_WORDS = 2,
    parameter bit USE_RING  = 1'b1,
    localparam int BLK_W    = WORD_W * BLK_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [BLK_W-1:0] push_blk,
    input  logic [BLK_W-1:0] state_blk,
    output logic [BLK_W-1:0] tap_a,
    output logic [BLK_W-1:0] tap_b
);

    buf_ctl_t         ctl;
    logic [BLK_W-1:0] last_stg, twist_src, new_first, new_twist;

    assign ctl = decode_ctl(rst, en, buf_mode_e'(mode));

    lfsr_fb #(
        .WORD_W   (WORD_W),
        .BLK_WORDS(BLK_WORDS),
        .ROT_WORDS(ROT_WORDS)
    ) u_fb (
        .sel_push (ctl.sel_push),
        .push_blk (push_blk),
        .state_blk(state_blk),
        .last_stg (last_stg),
        .twist_src(twist_src),
        .new_first(new_first),
        .new_twist(new_twist)
    );

    if (USE_RING) begin : g_ring
        lfsr_store_ring #(
            .BLK_W(BLK_W), .STAGES(STAGES), .TAP_A(TAP_A),
            .TAP_B(TAP_B), .TWIST_STG(TWIST_STG)
        ) u_store (
            .clk(clk), .clr(ctl.clr), .adv(ctl.adv),
            .new_first(new_first), .new_twist(new_twist),
            .tap_a(tap_a), .tap_b(tap_b),
            .twist_src(twist_src), .last_stg(last_stg)
        );
    end else begin : g_shift
        lfsr_store_shift #(
            .BLK_W(BLK_W), .STAGES(STAGES), .TAP_A(TAP_A),
            .TAP_B(TAP_B), .TWIST_STG(TWIST_STG)
        ) u_store (
            .clk(clk), .clr(ctl.clr), .adv(ctl.adv),
            .new_first(new_first), .new_twist(new_twist),
            .tap_a(tap_a), .tap_b(tap_b),
            .twist_src(twist_src), .last_stg(last_stg)
        );
    end

endmodule

// File: rtl/lfsr_word_buf_chk.sv
module lfsr_word_buf_chk #(
    parameter int BLK_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [1:0]       mode,
    input logic [BLK_W-1:0] tap_a,
    input logic [BLK_W-1:0] tap_b
);

    logic       advancing;
    logic [3:0] run_cnt;

    assign advancing = en && (mode == 2'b01 || mode == 2'b10);

    // consecutive advances immediately before the current edge
    always_ff @(posedge clk) begin
        if (rst || !advancing) run_cnt <= '0;
        else if (run_cnt != 4'hF) run_cnt <= run_cnt + 4'd1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (tap_a == '0 && tap_b == '0));

    // R2
    clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b00) |=> (tap_a == '0 && tap_b == '0));

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(tap_a) && $stable(tap_b)));

    // R8
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b11) |=> ($stable(tap_a) && $stable(tap_b)));

    // R4
    plain_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 4'd12) |-> (tap_b == $past(tap_a, 12)));

endmodule

bind lfsr_word_buf lfsr_word_buf_chk #(.BLK_W(BLK_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .mode (mode),
    .tap_a(tap_a),
    .tap_b(tap_b)
);

// File: tb/sim_lfsr_word_buf.sv
`timescale 1ns/1ps
module sim_lfsr_word_buf;

    localparam int BW = 256;

    logic          clk = 1'b0;
    logic          rst, en;
    logic [1:0]    mode;
    logic [BW-1:0] push_blk, state_blk;
    logic [BW-1:0] ta0, tb0, ta1, tb1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    logic [BW-1:0] ref_st [32];

    always #2.5 clk = ~clk;

    lfsr_word_buf #(.USE_RING(1'b1)) u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .push_blk(push_blk), .state_blk(state_blk),
        .tap_a(ta0), .tap_b(tb0));

    lfsr_word_buf #(.USE_RING(1'b0)) u1 (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .push_blk(push_blk), .state_blk(state_blk),
        .tap_a(ta1), .tap_b(tb1));

    function automatic logic [BW-1:0] rot_words(logic [BW-1:0] b);
        logic [BW-1:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = b[((i + 2) % 8)*32 +: 32];
        return r;
    endfunction

    // behavioural reference
    always @(posedge clk) begin
        if (rst || (en && mode == 2'b00)) begin
            for (int j = 0; j < 32; j++) ref_st[j] = '0;
        end else if (en && (mode == 2'b01 || mode == 2'b10)) begin
            logic [BW-1:0] o31, o24, q;
            o31 = ref_st[31];
            o24 = ref_st[24];
            q   = (mode == 2'b01) ? push_blk : state_blk;
            for (int j = 31; j > 0; j--) ref_st[j] = ref_st[j-1];
            ref_st[0]  = o31 ^ q;
            ref_st[25] = o24 ^ rot_words(o31);
        end
    end

    task automatic check(string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] rnd_blk();
        logic [BW-1:0] b;
        for (int i = 0; i < 8; i++) b[i*32 +: 32] = $urandom;
        return b;
    endfunction

    // one cycle: drive at falling edge, compare at next falling edge
    task automatic cyc(logic r, logic e, logic [1:0] m, logic [BW-1:0] p, logic [BW-1:0] s);
        rst = r; en = e; mode = m; push_blk = p; state_blk = s;
        @(posedge clk);
        @(negedge clk);
        // R9: taps show current stages 4 and 16; R10: both variants agree
        check(cur_req, "ring tap_a", ta0, ref_st[4]);
        check(cur_req, "ring tap_b", tb0, ref_st[16]);
        check(cur_req, "shift tap_a", ta1, ref_st[4]);
        check(cur_req, "shift tap_b", tb1, ref_st[16]);
    endtask

    initial begin
        logic [BW-1:0] snap_a, snap_b;
        rst = 1'b1; en = 1'b0; mode = 2'b00; push_blk = '0; state_blk = '0;
        for (int j = 0; j < 32; j++) ref_st[j] = '0;
        @(negedge clk);

        cur_req = "R1";
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 2'b01, rnd_blk(), rnd_blk());
        check("R1", "reset tap_a zero", ta0, '0);

        // R5 R4 R6: random pushes, long enough to wrap stage 31 into 0 and 25
        cur_req = "R5";
        for (int k = 0; k < 45; k++) cyc(1'b0, 1'b1, 2'b01, rnd_blk(), rnd_blk());

        // R3: enable low, inputs change, nothing moves
        cur_req = "R3";
        snap_a = ta0; snap_b = tb0;
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 2'(k % 4), rnd_blk(), rnd_blk());
        check("R3", "hold tap_a", ta0, snap_a);
        check("R3", "hold tap_b", tb0, snap_b);

        // R7: pull mode uses state words as feedback
        cur_req = "R7";
        for (int k = 0; k < 45; k++) cyc(1'b0, 1'b1, 2'b10, rnd_blk(), rnd_blk());

        // R8: idle mode with enable high
        cur_req = "R8";
        snap_a = ta0; snap_b = tb0;
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, 2'b11, rnd_blk(), rnd_blk());
        check("R8", "idle tap_a", ta0, snap_a);
        check("R8", "idle tap_b", tb0, snap_b);

        // R2: clear mode
        cur_req = "R2";
        cyc(1'b0, 1'b1, 2'b00, rnd_blk(), rnd_blk());
        check("R2", "clear tap_a", ta0, '0);
        check("R2", "clear tap_b", tb1, '0);

        // R6 R4: single marked block walks round, twist visible via taps
        cur_req = "R6";
        cyc(1'b0, 1'b1, 2'b01, {8{32'h0000_0001}} ^ {32'h8, 32'h7, 32'h6, 32'h5,
                                 32'h4, 32'h3, 32'h2, 32'h1}, '0);
        for (int k = 0; k < 60; k++) cyc(1'b0, 1'b1, 2'b01, '0, '0);
        cur_req = "R4";
        for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, 2'b10, '0, rnd_blk());

        // R1: reset in mid-run
        cur_req = "R1";
        cyc(1'b1, 1'b1, 2'b10, rnd_blk(), rnd_blk());
        check("R1", "mid reset tap_b", tb0, '0);
        cur_req = "R10";
        for (int k = 0; k < 10; k++) cyc(1'b0, 1'b1, 2'b01, rnd_blk(), rnd_blk());

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule